// File: doc/BRIEF.md
# 64-bit Block Cipher Register Front End

This block is the software-visible face of a 64-bit block cipher engine. A processor programs key words, an initial chaining value and a mode word through a 32-bit memory-mapped port. It then moves data one 64-bit block at a time: it writes two data words, the engine runs, and it reads two result words back. The block handles the address decode, the ready flags, ECB or CBC chaining in either direction, single-key or triple-key selection, and a two-level interrupt scheme. That scheme asks for the next input block and announces each finished output block.

The cipher round function is not part of this block. A stand-in transform with a fixed latency `LAT` sits behind a start/done handshake, so that the sequencing and chaining can be exercised. A sequencer has three named states. `ST_LOAD` accepts input words and raises input-ready. `ST_BUSY` waits for the core. `ST_HOLD` holds the result with output-ready high. It has three named transitions: start (`ST_LOAD`→`ST_BUSY`, on the write of the low data word), latch (`ST_BUSY`→`ST_HOLD`, on core done) and drain (`ST_HOLD`→`ST_LOAD`, on the read of the low result word).

Top module: `blkc_regfront`

## Requirements
- R1: After reset the control word reads 0x2 (input-ready only), interrupt status and enable read 0, `irq` is low, and the IV, data, length and mask registers read 0.
- R2: Logical key word i (i = 0..5) is written at byte address 0x14 − 4·(i XOR 1), so words 0/1 are at 0x10/0x14, words 2/3 at 0x08/0x0C and words 4/5 at 0x00/0x04. Key addresses read as 0. The single-key value is {word0, word1}, with word0 in the upper half. In triple-key mode the key is {w0,w1} XOR {w2,w3} XOR {w4,w5}. Single-key mode ignores words 2 to 5.
- R3: Control at 0x20: bit 4 = CBC, bit 3 = triple-key, bit 2 = encrypt (1) or decrypt (0), bit 1 = input-ready (read-only), bit 0 = output-ready (read-only). Writes to the mode bits and to the IV words (0x18 upper, 0x1C lower) take effect only while input-ready is 1.
- R4: Data word 0x28 is the upper half and 0x2C the lower half of a block. Writing 0x2C while input-ready is 1 starts the block. Input-ready and the data-in status bit drop, and output-ready and the data-out status bit set when the result is latched.
- R5: The stand-in transform with key K is as follows. Encrypt: rotate (x XOR K) left by 8 bits over 64 bits. Decrypt: rotate x right by 8 bits, then XOR K. Decrypt therefore inverts encrypt.
- R6: Reading 0x2C while output-ready is 1 clears output-ready and the data-out status bit, and sets input-ready and the data-in status bit.
- R7: Writes to the data words while input-ready is 0 are ignored. They neither alter the stored input nor start a block.
- R8: CBC encrypt: the core input is data XOR IV, and the IV then becomes the ciphertext.
- R9: CBC decrypt: the output is the core result XOR IV, and the IV then becomes the incoming ciphertext.
- R10: Interrupt status at 0x3C and enable at 0x40 use bit 1 = data-in and bit 2 = data-out. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. `irq` is high when any status bit and its enable bit are both 1.
- R11: The revision word at 0x30 reports `MAJOR` in bits 10:8 and `MINOR` in bits 5:0, and reads 0 elsewhere.
- R12: The length word at 0x24 and the mask word at 0x34 are plain 32-bit read/write registers. Unmapped addresses read 0.
- R13: Output-ready rises exactly LAT+1 clock edges after the edge that accepts the low data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (has a side effect on 0x2C) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle. Input-ready and output-ready are never high together. A start drops input-ready and the data-in status. A drain restores input-ready. The busy phase lasts exactly LAT+1 cycles. Data and mode writes outside the load phase leave the stored values unchanged. A latch with the data-out enable set raises `irq`. Some behaviour only the directed scenarios can show: the pair-swapped key addresses, the key combination in triple mode, the transform values, the CBC chaining across several blocks in both directions, the write-zero-to-clear status semantics and the revision, length and mask contents.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
    localparam int AW  = 7;
    localparam int DW  = 32;
    localparam int BW  = 2 * DW;
    localparam int ROT = 8;

    localparam logic [AW-1:0] A_IV0   = 7'h18;
    localparam logic [AW-1:0] A_IV1   = 7'h1C;
    localparam logic [AW-1:0] A_CTRL  = 7'h20;
    localparam logic [AW-1:0] A_LEN   = 7'h24;
    localparam logic [AW-1:0] A_D0    = 7'h28;
    localparam logic [AW-1:0] A_D1    = 7'h2C;
    localparam logic [AW-1:0] A_REV   = 7'h30;
    localparam logic [AW-1:0] A_MASK  = 7'h34;
    localparam logic [AW-1:0] A_ISTAT = 7'h3C;
    localparam logic [AW-1:0] A_IEN   = 7'h40;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } seq_e;

    function automatic logic [BW-1:0] stub_xform(input logic [BW-1:0] x,
                                                 input logic [BW-1:0] k,
                                                 input logic enc);
        logic [BW-1:0] t;
        if (enc) begin
            t = x ^ k;
            return (t << ROT) | (t >> (BW - ROT));
        end
        t = (x >> ROT) | (x << (BW - ROT));
        return t ^ k;
    endfunction
endpackage

// File: rtl/blkc_keybank.sv
module blkc_keybank
    import blkc_pkg::*;
#(
    parameter int NWORDS  = 6,
    parameter int KEY_TOP = 'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          triple,
    output logic [BW-1:0] eff_key
);
    localparam int NPAIR = NWORDS / 2;

    logic [DW-1:0] kw [NWORDS];
    logic [BW-1:0] pair_x [NPAIR];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam int OFS = KEY_TOP - 4 * (g ^ 1);
        always_ff @(posedge clk) begin
            if (!rst_n)
                kw[g] <= '0;
            else if (wr && addr == OFS[AW-1:0])
                kw[g] <= wdata;
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        if (p == 0) begin : g_first
            assign pair_x[p] = {kw[0], kw[1]};
        end else begin : g_rest
            assign pair_x[p] = pair_x[p-1] ^ {kw[2*p], kw[2*p+1]};
        end
    end

    assign eff_key = triple ? pair_x[NPAIR-1] : pair_x[0];
endmodule

// File: rtl/blkc_stub_core.sv
module blkc_stub_core
    import blkc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          encrypt,
    input  logic [BW-1:0] key,
    input  logic [BW-1:0] blk_in,
    output logic          done,
    output logic [BW-1:0] blk_out
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic          busy;
    logic          enc_q;
    logic [BW-1:0] key_q;
    logic [BW-1:0] op_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            busy    <= 1'b0;
            enc_q   <= 1'b0;
            key_q   <= '0;
            op_q    <= '0;
            done    <= 1'b0;
            blk_out <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= CW'(LAT - 1);
                enc_q <= encrypt;
                key_q <= key;
                op_q  <= blk_in;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    blk_out <= stub_xform(op_q, key_q, enc_q);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/blkc_irq_unit.sv
module blkc_irq_unit #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_set,
    input  logic [NCH-1:0] hw_clr,
    input  logic           stat_we,
    input  logic           en_we,
    input  logic [NCH-1:0] sw_bits,
    output logic [NCH-1:0] stat,
    output logic [NCH-1:0] en,
    output logic           irq
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[c] <= 1'b0;
                en[c]   <= 1'b0;
            end else begin
                if (hw_set[c])
                    stat[c] <= 1'b1;
                else if (hw_clr[c] || (stat_we && !sw_bits[c]))
                    stat[c] <= 1'b0;
                if (en_we)
                    en[c] <= sw_bits[c];
            end
        end
    end

    assign irq = |(stat & en);
endmodule

// File: rtl/blkc_regfront.sv
module blkc_regfront
    import blkc_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int MAJOR = 2,
    parameter int MINOR = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam logic [2:0] MAJ_F = MAJOR[2:0];
    localparam logic [5:0] MIN_F = MINOR[5:0];
    localparam logic [DW-1:0] REV_WORD = {21'b0, MAJ_F, 2'b0, MIN_F};

    seq_e          state, state_nx;
    logic [2:0]    mode;          // {cbc, triple, encrypt}
    logic [DW-1:0] in_w0, in_w1, out_w0, out_w1, iv0, iv1, len_r, mask_r;
    logic          in_rdy, out_rdy, start, latch, drain;
    logic [BW-1:0] eff_key, core_in, core_out, iv_blk, in_blk;
    logic          core_done;
    logic [1:0]    stat, en;      // [1]=data-out, [0]=data-in

    wire cbc = mode[2];
    wire enc = mode[0];
    assign iv_blk = {iv0, iv1};
    assign in_blk = {in_w0, in_w1};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: if (bus_wr && bus_addr == A_D1) state_nx = ST_BUSY;
            ST_BUSY: if (core_done)                  state_nx = ST_HOLD;
            ST_HOLD: if (bus_rd && bus_addr == A_D1) state_nx = ST_LOAD;
            default:                                 state_nx = ST_LOAD;
        endcase
    end

    always_comb begin
        in_rdy  = (state == ST_LOAD);
        out_rdy = (state == ST_HOLD);
        start   = in_rdy && bus_wr && bus_addr == A_D1;
        latch   = (state == ST_BUSY) && core_done;
        drain   = out_rdy && bus_rd && bus_addr == A_D1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0; in_w0 <= '0; in_w1 <= '0; out_w0 <= '0; out_w1 <= '0;
            iv0 <= '0; iv1 <= '0; len_r <= '0; mask_r <= '0;
        end else begin
            if (bus_wr && bus_addr == A_LEN)  len_r  <= bus_wdata;
            if (bus_wr && bus_addr == A_MASK) mask_r <= bus_wdata;
            if (in_rdy && bus_wr) begin
                if (bus_addr == A_CTRL) mode  <= bus_wdata[4:2];
                if (bus_addr == A_IV0)  iv0   <= bus_wdata;
                if (bus_addr == A_IV1)  iv1   <= bus_wdata;
                if (bus_addr == A_D0)   in_w0 <= bus_wdata;
                if (bus_addr == A_D1)   in_w1 <= bus_wdata;
            end
            if (latch) begin
                {out_w0, out_w1} <= (cbc && !enc) ? (core_out ^ iv_blk) : core_out;
                if (cbc) {iv0, iv1} <= enc ? core_out : in_blk;
            end
        end
    end

    assign core_in = {in_w0, bus_wdata} ^ ((cbc && enc) ? iv_blk : '0);

    blkc_keybank u_keys (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .triple(mode[1]), .eff_key(eff_key)
    );

    blkc_stub_core #(.LAT(LAT)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .encrypt(enc),
        .key(eff_key), .blk_in(core_in), .done(core_done), .blk_out(core_out)
    );

    blkc_irq_unit #(.NCH(2)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .hw_set({latch, drain}), .hw_clr({drain, start}),
        .stat_we(bus_wr && bus_addr == A_ISTAT),
        .en_we(bus_wr && bus_addr == A_IEN),
        .sw_bits(bus_wdata[2:1]), .stat(stat), .en(en), .irq(irq)
    );

    always_comb begin
        case (bus_addr)
            A_IV0:   bus_rdata = iv0;
            A_IV1:   bus_rdata = iv1;
            A_CTRL:  bus_rdata = {27'b0, mode, in_rdy, out_rdy};
            A_LEN:   bus_rdata = len_r;
            A_D0:    bus_rdata = out_w0;
            A_D1:    bus_rdata = out_w1;
            A_REV:   bus_rdata = REV_WORD;
            A_MASK:  bus_rdata = mask_r;
            A_ISTAT: bus_rdata = {29'b0, stat, 1'b0};
            A_IEN:   bus_rdata = {29'b0, en, 1'b0};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkc_regfront_chk.sv
module blkc_regfront_chk
    import blkc_pkg::*;
#(
    parameter int LAT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic          busy,
    input logic [1:0]    stat,
    input logic [1:0]    en,
    input logic          irq,
    input logic [DW-1:0] in_w0,
    input logic [2:0]    mode
);
    int run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_rdy, out_rdy}));

    p_start_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && bus_wr && bus_addr == A_D1) |=> (!in_rdy && !stat[0]));

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && bus_rd && bus_addr == A_D1) |=> (in_rdy && !out_rdy && stat[0]));

    p_data_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy && bus_wr && bus_addr == A_D0) |=> $stable(in_w0));

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy && bus_wr && bus_addr == A_CTRL) |=> $stable(mode));

    p_irq_on_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_rdy) && en[1]) |-> irq);

    p_busy_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt <= LAT));

    p_busy_exact_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == LAT + 1));
endmodule

bind blkc_regfront blkc_regfront_chk #(.LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .busy(state == ST_BUSY), .stat(stat), .en(en), .irq(irq),
    .in_w0(in_w0), .mode(mode)
);

// File: tb/sim_blkc_regfront.sv
`timescale 1ns/1ps
module sim_blkc_regfront;
    localparam int LAT = 4;
    localparam logic [6:0] IV0 = 7'h18, IV1 = 7'h1C, CTRL = 7'h20, LEN = 7'h24,
        D0 = 7'h28, D1 = 7'h2C, REV = 7'h30, MASK = 7'h34, IST = 7'h3C, IEN = 7'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    blkc_regfront #(.LAT(LAT), .MAJOR(2), .MINOR(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [63:0] ref_enc(input logic [63:0] x, input logic [63:0] k);
        logic [63:0] t;
        t = x ^ k;
        return {t[55:0], t[63:56]};
    endfunction
    function automatic logic [63:0] ref_dec(input logic [63:0] y, input logic [63:0] k);
        return {y[7:0], y[63:8]} ^ k;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr32(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic wait_out();
        logic [31:0] c;
        for (int i = 0; i < 50; i++) begin
            rd32(CTRL, c);
            if (c[0]) return;
        end
        chk("R4 output-ready timeout", 0, 1);
    endtask

    task automatic run_block(input logic [63:0] x, output logic [63:0] y);
        logic [31:0] a, b;
        wr32(D0, x[63:32]);
        wr32(D1, x[31:0]);
        wait_out();
        rd32(D0, a);
        rd32(D1, b);
        y = {a, b};
    endtask

    task automatic set_keys(input logic [31:0] w[6]);
        for (int i = 0; i < 6; i++) wr32(7'(8'h14 - 4 * (i ^ 1)), w[i]);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd32(CTRL, d); chk("R1 ctrl", d, 32'h2);
        rd32(IST, d);  chk("R1 status", d, 0);
        rd32(IEN, d);  chk("R1 enable", d, 0);
        chk("R1 irq", irq, 0);
        rd32(IV0, d);  chk("R1 iv0", d, 0);
        rd32(D0, d);   chk("R1 d0", d, 0);
        rd32(LEN, d);  chk("R1 len", d, 0);
    endtask

    task automatic t_single();
        logic [31:0] w[6] = '{32'h01234567, 32'h89ABCDEF, 32'hDEAD0001,
                              32'hBEEF0002, 32'hCAFE0003, 32'hF00D0004};
        logic [63:0] k = {w[0], w[1]}, pt = 64'h1122334455667788, ct, back;
        logic [31:0] d;
        set_keys(w);
        rd32(7'h10, d); chk("R2 key reads zero", d, 0);
        wr32(CTRL, 32'h4);
        run_block(pt, ct);
        chk("R2 R5 single-key encrypt", ct, ref_enc(pt, k));
        wr32(CTRL, 32'h0);
        run_block(ct, back);
        chk("R5 decrypt inverts", back, pt);
    endtask

    task automatic t_triple();
        logic [31:0] w[6] = '{32'h10000001, 32'h20000002, 32'h30000300,
                              32'h40004000, 32'h00500005, 32'h06000060};
        logic [63:0] k, pt = 64'h0F1E2D3C4B5A6978, ct;
        k = {w[0], w[1]} ^ {w[2], w[3]} ^ {w[4], w[5]};
        set_keys(w);
        wr32(CTRL, 32'hC);
        run_block(pt, ct);
        chk("R2 triple-key encrypt", ct, ref_enc(pt, k));
    endtask

    task automatic t_cbc();
        logic [31:0] w[6] = '{32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0, 0, 0};
        logic [63:0] k = {w[0], w[1]}, iv = 64'h0102030405060708;
        logic [63:0] p0 = 64'hAAAA0000BBBB1111, p1 = 64'h1234123412341234;
        logic [63:0] c0, c1, e0, e1, q0, q1;
        logic [31:0] a, b;
        set_keys(w);
        wr32(IV0, iv[63:32]); wr32(IV1, iv[31:0]);
        wr32(CTRL, 32'h14);
        e0 = ref_enc(p0 ^ iv, k);
        e1 = ref_enc(p1 ^ e0, k);
        run_block(p0, c0); chk("R8 cbc enc block0", c0, e0);
        run_block(p1, c1); chk("R8 cbc enc block1", c1, e1);
        rd32(IV0, a); rd32(IV1, b); chk("R8 iv becomes ciphertext", {a, b}, e1);
        wr32(IV0, iv[63:32]); wr32(IV1, iv[31:0]);
        wr32(CTRL, 32'h10);
        run_block(c0, q0); chk("R9 cbc dec block0", q0, p0);
        run_block(c1, q1); chk("R9 cbc dec block1", q1, p1);
        rd32(IV0, a); rd32(IV1, b); chk("R9 iv becomes input", {a, b}, c1);
    endtask

    task automatic t_ignore();
        logic [31:0] w[6] = '{32'h0000FFFF, 32'hFFFF0000, 0, 0, 0, 0};
        logic [63:0] k = {w[0], w[1]}, x = 64'h7777666655554444, y, y2;
        logic [31:0] a, b, c;
        set_keys(w);
        wr32(IV0, 0); wr32(IV1, 0);
        wr32(CTRL, 32'h4);
        wr32(D0, x[63:32]);
        wr32(D1, x[31:0]);
        wr32(CTRL, 32'h18);
        wr32(IV0, 32'h99999999);
        wait_out();
        wr32(D0, 32'h12121212);
        wr32(D1, 32'h34343434);
        rd32(CTRL, c); chk("R3 mode write ignored while busy", c, 32'h5);
        rd32(D0, a); rd32(D1, b);
        chk("R7 result unaffected", {a, b}, ref_enc(x, k));
        rd32(IV0, c); chk("R3 iv write ignored", c, 0);
        wr32(D1, 32'h00001111);
        wait_out();
        rd32(D0, a); rd32(D1, b);
        y = {x[63:32], 32'h00001111};
        chk("R7 stored upper word kept", {a, b}, ref_enc(y, k));
        y2 = y;
    endtask

    task automatic t_latency_irq();
        logic [31:0] d;
        int n;
        wr32(IEN, 32'h4);
        wr32(D0, 32'h1);
        wr32(D1, 32'h2);
        bus_addr = CTRL;
        n = 0;
        @(negedge clk);
        chk("R4 input-ready drops", bus_rdata[1], 0);
        while (!bus_rdata[0] && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R13 latency", n, LAT + 1);
        chk("R10 irq on data-out", irq, 1);
        rd32(IST, d); chk("R4 data-out status set", d, 32'h4);
        wr32(IST, 32'h6); rd32(IST, d); chk("R10 write-1 no effect", d, 32'h4);
        wr32(IST, 32'h0); rd32(IST, d); chk("R10 write-0 clears", d, 0);
        chk("R10 irq low after clear", irq, 0);
        rd32(D0, d); rd32(D1, d);
        rd32(CTRL, d); chk("R6 drain restores input-ready", d[1:0], 2'b10);
        rd32(IST, d);  chk("R6 data-in status set", d, 32'h2);
        chk("R10 data-in masked", irq, 0);
        wr32(IEN, 32'h2);
        chk("R10 irq on data-in", irq, 1);
        wr32(IST, 32'h4);
        chk("R10 data-in cleared", irq, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        rd32(REV, d); chk("R11 revision", d, 32'h205);
        wr32(LEN, 32'hC0FFEE11); rd32(LEN, d); chk("R12 length", d, 32'hC0FFEE11);
        wr32(MASK, 32'h00000060); rd32(MASK, d); chk("R12 mask", d, 32'h60);
        wr32(7'h38, 32'hFFFFFFFF); rd32(7'h38, d); chk("R12 unmapped", d, 0);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_triple();
        t_cbc();
        t_ignore();
        t_latency_irq();
        t_regs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule